// File: doc/BRIEF.md
# Address-Flagged Asynchronous Serial Transmitter

This block serialises bytes onto a single asynchronous line. After the data bits of every character it sends one extra flag bit, which tells the listening stations how to treat that character. A flag of 1 means the character names the station that should receive what follows. A flag of 0 means the character is payload for the station already named. The flag takes the place that a parity bit would otherwise hold, so no parity is ever sent.

A producer hands over one byte at a time, together with its flag, through a valid/ready channel into a one-entry holding register. The ready signal doubles as the holding-register-empty flag. Only the handshake moves data, so a producer that sees ready low simply keeps valid high, or retries, until ready returns. A request output, qualified by the transmit enable, lets a DMA engine refill the holding register; the accepting handshake clears the flag. The baud rate is supplied from outside as a one-cycle bit tick, and each serial bit lasts one tick period.

Lowering the transmit enable stops the line at once. The line then rests at a level set by a break-select input: low for a break, high for idle.

Top module: `mpx_uart_tx`

## Requirements
- R1: During and directly after reset, with tx_en low and brk_sel low, txd is 1, tdr_empty is 1, wr_ready is 1 and txe_req is 0.
- R2: Each frame is sent in this order: a start bit of 0, then the data bits LSB first, then the flag bit, then the stop bits of 1. Every bit lasts exactly one bit_tick period, and a frame begins only on a cycle where bit_tick is 1.
- R3: fmt_7bit=1 sends 7 data bits (wr_data[6:0]) and fmt_7bit=0 sends 8. fmt_2stop=1 sends two stop bits and fmt_2stop=0 sends one. This gives four frame formats.
- R4: parity_en has no effect on any frame. No parity bit is ever inserted.
- R5: The flag bit on the line equals the wr_mpb value written with that byte: 1 for a station address, 0 for data.
- R6: A write is accepted only on a cycle where wr_valid and wr_ready are both 1. Acceptance clears tdr_empty (and wr_ready) on the next cycle. A write offered while wr_ready is 0 is dropped and never reaches the line. tdr_empty never falls without an accepted write.
- R7: tdr_empty returns to 1 on the bit tick at which the held byte moves into the shifter, which is the start of its frame, and at no other time. A byte waiting in the holding register starts on the tick that ends the previous frame's last stop bit, so no idle bit separates the two frames.
- R8: The data and flag of a frame are captured when it moves into the shifter. A write accepted during that frame does not change it.
- R9: txe_req is 1 exactly when tdr_empty is 1 and tx_en is 1.
- R10: While tx_en is 0, any frame in flight is abandoned and txd is 0 if brk_sel is 1, or 1 if brk_sel is 0. After tx_en returns to 1, the line idles at 1 until the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each serial bit boundary |
| tx_en | input | 1 | Transmit enable; low abandons the frame and stops the line |
| brk_sel | input | 1 | Line level while disabled: 1 drives a break (low) |
| fmt_7bit | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| fmt_2stop | input | 1 | 1 selects two stop bits, 0 selects one |
| parity_en | input | 1 | Parity setting, ignored in this format |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | 8 | Byte to send |
| wr_mpb | input | 1 | Flag bit sent with the byte (1 address, 0 data) |
| wr_ready | output | 1 | Holding register can accept a byte |
| tdr_empty | output | 1 | Holding register empty flag |
| txe_req | output | 1 | Refill request for a DMA engine |
| txd | output | 1 | Serial line |

## Verification
The frame checks use random bytes and random flag values under each of the four formats, with parity_en toggled on every write, plus the all-zero and all-one bytes. These tell apart errors in bit order, data width, stop count and flag placement, and any leak of parity into the frame. A directed back-to-back pair, written while the first frame is on the line and followed by a write offered against a low ready, separates an empty flag that returns at frame start from one that returns at frame end. The same sequence shows whether a late write can reach the line or alter the frame in flight. A frame abandoned mid-way by dropping the enable, tried with both break levels, shows whether the line follows the break select and whether the holding side is left consistent.

// File: rtl/mpx_uart_pkg.sv
package mpx_uart_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned FRAME_W  = DATA_W + 4;
  localparam int unsigned LEN_W    = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              mpb;
  } hold_t;
endpackage

// File: rtl/mpx_hold_reg.sv
module mpx_hold_reg
  import mpx_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  input  logic              take,
  output logic              wr_ready,
  output hold_t             held,
  output logic              full
);
  // take is only raised while full, a write only lands while empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
    end else if (take) begin
      full <= 1'b0;
    end else if (wr_valid && !full) begin
      full      <= 1'b1;
      held.data <= wr_data;
      held.mpb  <= wr_mpb;
    end
  end

  assign wr_ready = !full;
endmodule

// File: rtl/mpx_frame_build.sv
module mpx_frame_build
  import mpx_uart_pkg::*;
(
  input  hold_t              held,
  input  logic               fmt_7bit,
  input  logic               fmt_2stop,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  logic [LEN_W-1:0] dbits;

  always_comb begin
    dbits = fmt_7bit ? LEN_W'(DATA_W - 1) : LEN_W'(DATA_W);
    frame = '1;              // unused upper positions stay at stop level
    frame[0] = 1'b0;         // start bit
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) < dbits) frame[1+i] = held.data[i];
    end
    frame[dbits + LEN_W'(1)] = held.mpb;
    len = dbits + (fmt_2stop ? LEN_W'(4) : LEN_W'(3));
  end
endmodule

// File: rtl/mpx_shifter.sv
module mpx_shifter
  import mpx_uart_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               bit_tick,
  input  logic               hold_full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  output logic               take,
  output logic               ser
);
  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   rem;
  logic               busy;
  logic               last;

  assign last = busy && (rem == LEN_W'(1));
  assign take = tx_en && bit_tick && hold_full && (!busy || last);
  assign ser  = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      rem  <= '0;
      busy <= 1'b0;
    end else if (!tx_en) begin
      sh   <= '1;
      rem  <= '0;
      busy <= 1'b0;
    end else if (bit_tick) begin
      if (take) begin
        sh   <= frame;
        rem  <= len;
        busy <= 1'b1;
      end else if (busy) begin
        sh  <= {1'b1, sh[FRAME_W-1:1]};
        rem <= rem - LEN_W'(1);
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpx_line_drv.sv
module mpx_line_drv (
  input  logic tx_en,
  input  logic brk_sel,
  input  logic ser,
  output logic txd
);
  // disabled: break pulls low, otherwise rest at mark level
  assign txd = tx_en ? ser : !brk_sel;
endmodule

// File: rtl/mpx_uart_tx.sv
module mpx_uart_tx
  import mpx_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic              brk_sel,
  input  logic              fmt_7bit,
  input  logic              fmt_2stop,
  input  logic              parity_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  output logic              wr_ready,
  output logic              tdr_empty,
  output logic              txe_req,
  output logic              txd
);
  hold_t              held;
  logic               full;
  logic               take;
  logic               ser;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               unused_parity;

  assign unused_parity = parity_en;

  mpx_hold_reg u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_mpb(wr_mpb), .take(take), .wr_ready(wr_ready), .held(held), .full(full)
  );

  mpx_frame_build u_build (
    .held(held), .fmt_7bit(fmt_7bit), .fmt_2stop(fmt_2stop),
    .frame(frame), .len(len)
  );

  mpx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
    .hold_full(full), .frame(frame), .len(len), .take(take), .ser(ser)
  );

  mpx_line_drv u_line (
    .tx_en(tx_en), .brk_sel(brk_sel), .ser(ser), .txd(txd)
  );

  assign tdr_empty = !full;
  assign txe_req   = tx_en && !full;
endmodule

// File: rtl/mpx_uart_tx_chk.sv
module mpx_uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_en,
  input logic brk_sel,
  input logic wr_valid,
  input logic wr_ready,
  input logic tdr_empty,
  input logic txd
);
  assert_accept_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tdr_empty);

  assert_no_spurious_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && tdr_empty) |=> tdr_empty);

  assert_empty_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdr_empty) |-> $past(bit_tick));

  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(txd) && tx_en && $past(tx_en)) |-> $past(bit_tick));

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && $past(!tx_en) && $stable(brk_sel)) |-> $stable(txd));
endmodule

bind mpx_uart_tx mpx_uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
  .brk_sel(brk_sel), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .tdr_empty(tdr_empty), .txd(txd)
);

// File: tb/mpx_uart_tx_tb.sv
module mpx_uart_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_en = 1'b0;
  logic       brk_sel = 1'b0;
  logic       fmt_7bit = 1'b0;
  logic       fmt_2stop = 1'b0;
  logic       parity_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_mpb = 1'b0;
  logic       wr_ready, tdr_empty, txe_req, txd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mpx_uart_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .brk_sel(brk_sel), .fmt_7bit(fmt_7bit), .fmt_2stop(fmt_2stop),
    .parity_en(parity_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_mpb(wr_mpb), .wr_ready(wr_ready), .tdr_empty(tdr_empty),
    .txe_req(txe_req), .txd(txd)
  );

  always #4 clk = ~clk;

  // bit tick: one cycle in four
  logic [1:0] div = 2'd0;
  always @(posedge clk) begin
    div      <= div + 2'd1;
    bit_tick <= (div == 2'd2);
  end

  // expected-frame bookkeeping
  logic [7:0] exp_data [0:63];
  logic       exp_mpb  [0:63];
  int         start_tk [0:63];
  int         end_tk   [0:63];
  int wr_idx = 0;
  int exp_rd = 0;
  int tick_no = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic m,
                                            input logic f7);
    logic [11:0] f;
    int nd;
    f = '1;
    f[0] = 1'b0;
    nd = f7 ? 7 : 8;
    for (int i = 0; i < nd; i++) f[1+i] = d[i];
    f[1+nd] = m;
    return f;
  endfunction

  function automatic int exp_len(input logic f7, input logic s2);
    return 2 + (f7 ? 7 : 8) + (s2 ? 2 : 1);
  endfunction

  // line receiver: a bit's value is read on the tick that closes it
  bit          rx_act = 0;
  int          rx_cnt = 0;
  logic [11:0] rx_bits;
  always @(negedge clk) begin
    if (bit_tick) tick_no++;
    if (!rst_n || !tx_en) begin
      rx_act = 0;
    end else if (bit_tick) begin
      if (!rx_act) begin
        if (txd == 1'b0) begin
          rx_act = 1;
          rx_cnt = 1;
          rx_bits = '1;
          rx_bits[0] = 1'b0;
          start_tk[exp_rd] = tick_no;
        end
      end else begin
        rx_bits[rx_cnt] = txd;
        rx_cnt++;
        if (rx_cnt == exp_len(fmt_7bit, fmt_2stop)) begin
          rx_act = 0;
          end_tk[exp_rd] = tick_no;
          // R2 R3 R5 R8: order, width, stops and captured flag
          check(exp_rd < wr_idx && rx_bits == exp_frame(exp_data[exp_rd], exp_mpb[exp_rd], fmt_7bit),
                "R2/R3/R5 frame", int'(rx_bits),
                int'(exp_frame(exp_data[exp_rd], exp_mpb[exp_rd], fmt_7bit)));
          exp_rd++;
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [7:0] d, input logic m);
    while (!wr_ready) cyc(1);
    wr_valid = 1'b1; wr_data = d; wr_mpb = m;
    parity_en = $urandom_range(0, 1);   // R4: parity toggled, must not matter
    exp_data[wr_idx] = d; exp_mpb[wr_idx] = m; wr_idx++;
    cyc(1);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_rd < wr_idx || !tdr_empty) cyc(1);
    cyc(8);
  endtask

  int k;
  initial begin
    void'($urandom(32'h5eed));
    cyc(3);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(tdr_empty == 1'b1, "R1 tdr_empty", tdr_empty, 1);
    check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    check(txe_req == 1'b0, "R1 txe_req", txe_req, 0);
    rst_n = 1'b1;
    cyc(2);
    check(txd == 1'b1 && tdr_empty == 1'b1, "R1 after release", {txd, tdr_empty}, 3);

    // R10 break level while disabled
    brk_sel = 1'b1; cyc(2);
    check(txd == 1'b0, "R10 break", txd, 0);
    brk_sel = 1'b0; cyc(2);
    check(txd == 1'b1, "R10 idle", txd, 1);
    check(txe_req == 1'b0, "R9 off", txe_req, 0);

    tx_en = 1'b1; cyc(1);
    check(txe_req == 1'b1, "R9 request", txe_req, 1);

    // directed single frame, then the handshake clearing the flag
    push(8'hA5, 1'b1);
    check(tdr_empty == 1'b0 && txe_req == 1'b0, "R6/R9 after write",
          {tdr_empty, txe_req}, 0);
    drain();

    // R7 R8 back-to-back; R6 write against low ready is dropped
    push(8'h3C, 1'b1);
    push(8'hC3, 1'b0);   // lands while 3C is on the line
    check(wr_ready == 1'b0, "R6 ready low", wr_ready, 0);
    wr_valid = 1'b1; wr_data = 8'hFF; wr_mpb = 1'b1;
    cyc(1);
    wr_valid = 1'b0;
    k = wr_idx - 2;
    drain();
    check(exp_rd == wr_idx, "R6 frame count", exp_rd, wr_idx);
    check(start_tk[k+1] - end_tk[k] == 1, "R7 no gap",
          start_tk[k+1] - end_tk[k], 1);

    // all four formats with random bytes and flags
    for (int f = 0; f < 4; f++) begin
      fmt_7bit = f[0]; fmt_2stop = f[1];
      cyc(2);
      push(8'h00, 1'b0);
      push(8'hFF, 1'b1);
      for (int n = 0; n < 8; n++) push(8'($urandom), 1'($urandom));
      drain();
    end
    fmt_7bit = 1'b0; fmt_2stop = 1'b0;

    // R10 abort mid-frame with break, then recovery
    push(8'h00, 1'b0);
    while (!tdr_empty) cyc(1);
    cyc(12);
    brk_sel = 1'b1; tx_en = 1'b0;
    cyc(1);
    exp_rd++;            // abandoned frame is not expected
    cyc(2);
    check(txd == 1'b0, "R10 abort break", txd, 0);
    check(tdr_empty == 1'b1, "R7 empty after abort", tdr_empty, 1);
    brk_sel = 1'b0; tx_en = 1'b1;
    cyc(60);
    check(txd == 1'b1, "R10 idle after abort", txd, 1);
    push(8'h5A, 1'b1);
    drain();
    check(exp_rd == wr_idx, "R2 all frames seen", exp_rd, wr_idx);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", exp_rd, wr_idx);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule